// File: doc/BRIEF.md
# Priority Interrupt Resolver

The resolver looks at 64 interrupt sources at once and decides what a processor core should be told about them. Each source has a pending bit, an enable bit, a type bit and a 4-bit priority. Sources whose type bit is set belong to the fast class. All other sources belong to the normal class. The block drives two request lines, one per class. For each class it also reports which source wins, so that the number can be placed in a vector-status register by the surrounding logic.

The normal class is filtered by a 5-bit threshold. A source only raises the normal request when its priority is strictly above the threshold. The all-ones threshold value switches the filter off. The normal winner is the active normal source with the largest priority, and ties go to the higher source number. The fast class ignores priorities and the threshold: the lowest-numbered active fast source wins.

The selection logic is purely combinational. A parameter can add one register stage on the outputs, and the clock and reset exist only for that stage. Register decode, bus access and capture of source levels belong to the neighbouring logic.

Top module: `pir_resolver`

## Requirements
- R1: The priority of source n is bits [4n+3:4n] of `prio_fields`, which is the same as nibble n mod 8 of 32-bit word n/8.
- R2: A source is active when its `src_pending` and `src_enable` bits are both 1. An active source with its `src_fast` bit at 1 is fast; with `src_fast` at 0 it is normal. Inactive sources have no effect on any output.
- R3: `fast_req` is 1 exactly when at least one active fast source exists, whatever the priorities and the threshold.
- R4: When `mask_level` is 5'h1F, `norm_req` is 1 exactly when at least one active normal source exists.
- R5: For any other `mask_level`, `norm_req` is 1 exactly when some active normal source has a priority strictly greater than `mask_level`. Threshold values 15 to 30 therefore never raise it.
- R6: `norm_valid` is 1 when any active normal source exists. `norm_id` and `norm_prio` then give the source with the highest priority, with ties won by the highest source number. With no active normal source, `norm_id` and `norm_prio` are 0.
- R7: `fast_valid` is 1 when any active fast source exists, and `fast_id` is then the lowest-numbered one. Otherwise `fast_id` is 0.
- R8: With `REG_OUT`=1, every output reflects the inputs one clock earlier. The active-low asynchronous `rst_n` forces all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| src_pending | input | 64 | Pending bit per source |
| src_enable | input | 64 | Enable bit per source |
| src_fast | input | 64 | Type bit per source (1 = fast) |
| prio_fields | input | 256 | Packed 4-bit priority per source |
| mask_level | input | 5 | Normal-class threshold; 5'h1F disables gating |
| norm_req | output | 1 | Normal interrupt request |
| norm_valid | output | 1 | A normal winner exists |
| norm_id | output | 6 | Number of the normal winner |
| norm_prio | output | 4 | Priority of the normal winner |
| fast_req | output | 1 | Fast interrupt request |
| fast_valid | output | 1 | A fast winner exists |
| fast_id | output | 6 | Number of the fast winner |

## Verification
The assertions check the following on every cycle:
- a reported normal winner is an active normal source and carries its own priority field;
- a reported fast winner is active and fast, and no lower-numbered source is both;
- with gating on, a raised normal request always sits above the threshold;
- with gating off, the normal request follows the valid flag.

Some behaviour cannot be seen from a single winner's properties. The highest-number tie rule, the exact threshold boundary, the choice of winner among many candidates and the one-cycle output latency are only shown by the bench. It does this by comparing every output each clock against a behavioural scan over directed and random source patterns.

// File: rtl/pir_pkg.sv
package pir_pkg;

    localparam int PIR_NUM_SRC = 64;
    localparam int PIR_PRIO_W  = 4;
    localparam int PIR_MASK_W  = 5;

    // Decides whether the upper (higher-numbered) candidate displaces the lower one.
    // Equal priority favours the upper candidate, so ties go to the larger number.
    function automatic logic upper_wins(input logic up_v, input logic [7:0] up_p,
                                        input logic lo_v, input logic [7:0] lo_p);
        return up_v && (!lo_v || (up_p >= lo_p));
    endfunction

endpackage

// File: rtl/pir_norm_tree.sv
module pir_norm_tree
    import pir_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int PRIO_W  = 4,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int LVL    = $clog2(NUM_SRC),
    localparam int NPAD   = 1 << LVL
) (
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_fields,
    output logic                      win_valid,
    output logic [ID_W-1:0]           win_id,
    output logic [PRIO_W-1:0]         win_prio
);

    genvar lv;
    generate
        for (lv = 0; lv <= LVL; lv++) begin : g_lvl
            localparam int W = NPAD >> lv;
            logic              v [W];
            logic [ID_W-1:0]   id[W];
            logic [PRIO_W-1:0] p [W];
            if (lv == 0) begin : g_leaf
                for (genvar i = 0; i < W; i++) begin : g_src
                    if (i < NUM_SRC) begin : g_real
                        assign v[i]  = cand[i];
                        assign id[i] = ID_W'(i);
                        assign p[i]  = prio_fields[i*PRIO_W +: PRIO_W];
                    end else begin : g_pad
                        assign v[i]  = 1'b0;
                        assign id[i] = '0;
                        assign p[i]  = '0;
                    end
                end
            end else begin : g_node
                for (genvar k = 0; k < W; k++) begin : g_pair
                    logic take_up;
                    assign take_up = upper_wins(g_lvl[lv-1].v[2*k+1],
                                                8'(g_lvl[lv-1].p[2*k+1]),
                                                g_lvl[lv-1].v[2*k],
                                                8'(g_lvl[lv-1].p[2*k]));
                    assign v[k]  = g_lvl[lv-1].v[2*k] | g_lvl[lv-1].v[2*k+1];
                    assign id[k] = take_up ? g_lvl[lv-1].id[2*k+1] : g_lvl[lv-1].id[2*k];
                    assign p[k]  = take_up ? g_lvl[lv-1].p[2*k+1]  : g_lvl[lv-1].p[2*k];
                end
            end
        end
    endgenerate

    assign win_valid = g_lvl[LVL].v[0];
    assign win_id    = g_lvl[LVL].v[0] ? g_lvl[LVL].id[0] : '0;
    assign win_prio  = g_lvl[LVL].v[0] ? g_lvl[LVL].p[0]  : '0;

endmodule

// File: rtl/pir_fast_find.sv
module pir_fast_find #(
    parameter int NUM_SRC = 64,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic               found,
    output logic [ID_W-1:0]    first_id
);

    always_comb begin
        first_id = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) first_id = ID_W'(i);
        end
    end

    assign found = |cand;

endmodule

// File: rtl/pir_out_stage.sv
module pir_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_comb
            assign q = rst_n ? d : '0;
        end
    endgenerate

endmodule

// File: rtl/pir_resolver.sv
module pir_resolver
    import pir_pkg::*;
#(
    parameter int NUM_SRC = PIR_NUM_SRC,
    parameter int PRIO_W  = PIR_PRIO_W,
    parameter int MASK_W  = PIR_MASK_W,
    parameter bit REG_OUT = 1'b1,
    localparam int ID_W   = $clog2(NUM_SRC),
    localparam int OUT_W  = 4 + 2*ID_W + PRIO_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pending,
    input  logic [NUM_SRC-1:0]        src_enable,
    input  logic [NUM_SRC-1:0]        src_fast,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_fields,
    input  logic [MASK_W-1:0]         mask_level,
    output logic                      norm_req,
    output logic                      norm_valid,
    output logic [ID_W-1:0]           norm_id,
    output logic [PRIO_W-1:0]         norm_prio,
    output logic                      fast_req,
    output logic                      fast_valid,
    output logic [ID_W-1:0]           fast_id
);

    localparam logic [MASK_W-1:0] GATE_OFF = '1;

    logic [NUM_SRC-1:0] act, act_norm, act_fast;
    logic               nv_c, fv_c, nreq_c;
    logic [ID_W-1:0]    nid_c, fid_c;
    logic [PRIO_W-1:0]  np_c;
    logic [OUT_W-1:0]   pack_d, pack_q;

    assign act      = src_pending & src_enable;
    assign act_norm = act & ~src_fast;
    assign act_fast = act & src_fast;

    pir_norm_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_norm (
        .cand(act_norm), .prio_fields(prio_fields),
        .win_valid(nv_c), .win_id(nid_c), .win_prio(np_c)
    );

    pir_fast_find #(.NUM_SRC(NUM_SRC)) u_fast (
        .cand(act_fast), .found(fv_c), .first_id(fid_c)
    );

    // The winner carries the maximum priority, so comparing it alone is enough.
    always_comb begin
        if (mask_level == GATE_OFF) nreq_c = nv_c;
        else                        nreq_c = nv_c && ({{(MASK_W){1'b0}}, np_c} > (PRIO_W+MASK_W)'(mask_level));
    end

    assign pack_d = {nreq_c, nv_c, nid_c, np_c, fv_c, fv_c, fid_c};

    pir_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .d(pack_d), .q(pack_q)
    );

    assign {norm_req, norm_valid, norm_id, norm_prio, fast_req, fast_valid, fast_id} = pack_q;

    // Normal winner is a real active normal source and reports its own field (R2, R6)
    assert_norm_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_c |-> (act_norm[nid_c] && (prio_fields[nid_c*PRIO_W +: PRIO_W] == np_c)));

    // Fast winner is active fast and nothing lower-numbered is (R7)
    assert_fast_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fv_c |-> (act_fast[fid_c] && ((act_fast & ((NUM_SRC'(1) << fid_c) - NUM_SRC'(1))) == '0)));

    // Gated request must exceed the threshold (R5)
    assert_norm_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nreq_c && mask_level != GATE_OFF) |-> ({{(MASK_W){1'b0}}, np_c} > (PRIO_W+MASK_W)'(mask_level)));

    // Gating off: request follows the presence of any normal source (R4)
    assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_level == GATE_OFF) |-> (nreq_c == (act_norm != '0)));

    // Fast request independent of mask: present exactly when a fast source is (R3)
    assert_fast_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fv_c == (act_fast != '0)) && !(fv_c && !act_fast[fid_c]));

endmodule

// File: tb/test_pir_resolver.sv
`timescale 1ns/1ps
module test_pir_resolver;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  pend = '0, ena = '0, fst = '0;
    logic [255:0] prio = '0;
    logic [4:0]   mask = 5'h1F;
    logic         o_nreq, o_nv, o_freq, o_fv;
    logic [5:0]   o_nid, o_fid;
    logic [3:0]   o_np;

    int n_checks = 0, n_fail = 0;
    bit have_prev = 0;
    logic e_nreq, e_nv, e_freq, e_fv;
    logic [5:0] e_nid, e_fid;
    logic [3:0] e_np;

    always #5 clk = ~clk;

    pir_resolver i_pir_resolver (
        .clk(clk), .rst_n(rst_n), .src_pending(pend), .src_enable(ena), .src_fast(fst),
        .prio_fields(prio), .mask_level(mask),
        .norm_req(o_nreq), .norm_valid(o_nv), .norm_id(o_nid), .norm_prio(o_np),
        .fast_req(o_freq), .fast_valid(o_fv), .fast_id(o_fid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: linear scan over the sources
    task automatic model();
        int best;
        best = -1;
        e_nv = 0; e_nid = 0; e_np = 0; e_fv = 0; e_fid = 0;
        for (int i = 0; i < 64; i++) begin
            if (pend[i] && ena[i]) begin
                int p;
                p = int'(prio[4*i +: 4]);
                if (fst[i]) begin
                    if (!e_fv) begin e_fv = 1; e_fid = 6'(i); end
                end else if (p >= best) begin
                    best = p; e_nv = 1; e_nid = 6'(i); e_np = 4'(p);
                end
            end
        end
        e_freq = e_fv;
        if (mask == 5'h1F) e_nreq = e_nv;
        else               e_nreq = e_nv && (best > int'(mask));
    endtask

    task automatic compare_all();
        chk("R4/R5 norm_req", int'(o_nreq), int'(e_nreq));
        chk("R2/R6 norm_valid", int'(o_nv), int'(e_nv));
        chk("R6 norm_id", int'(o_nid), int'(e_nid));
        chk("R1/R6 norm_prio", int'(o_np), int'(e_np));
        chk("R3 fast_req", int'(o_freq), int'(e_freq));
        chk("R7 fast_valid", int'(o_fv), int'(e_fv));
        chk("R7 fast_id", int'(o_fid), int'(e_fid));
    endtask

    // Outputs lag inputs by one clock (R8): check last step's expectation, then apply new inputs
    task automatic step(input logic [63:0] p, input logic [63:0] e, input logic [63:0] f,
                        input logic [255:0] pr, input logic [4:0] m);
        @(negedge clk);
        if (have_prev) compare_all();
        pend = p; ena = e; fst = f; prio = pr; mask = m;
        model();
        have_prev = 1;
    endtask

    function automatic logic [255:0] setp(input logic [255:0] base, input int src, input logic [3:0] v);
        logic [255:0] r;
        r = base;
        r[4*src +: 4] = v;
        return r;
    endfunction

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [255:0] pr;
        pend = '1; ena = '1; fst = 64'h0F;
        repeat (3) @(negedge clk);
        // Reset forces all outputs low (R8)
        chk("R8 reset norm_req", int'(o_nreq), 0);
        chk("R8 reset norm_valid", int'(o_nv), 0);
        chk("R8 reset fast_req", int'(o_freq), 0);
        chk("R8 reset fast_id", int'(o_fid), 0);
        rst_n = 1'b1;
        // Idle
        step('0, '0, '0, '0, 5'h1F);
        // R1: source 13 -> word 1 nibble 5, priority 11, mask 10
        pr = setp('0, 13, 4'hB);
        step(64'(1) << 13, '1, '0, pr, 5'd10);
        // R5 boundary: priority equal to mask -> no request
        step(64'(1) << 13, '1, '0, pr, 5'd11);
        // R5: threshold above 15 never requests
        step(64'(1) << 13, '1, '0, pr, 5'd20);
        // R4: gating off with priority 0
        step(64'(1) << 2, '1, '0, '0, 5'h1F);
        // R6 tie: sources 5 and 40 at priority 9 -> 40
        pr = setp(setp('0, 5, 4'h9), 40, 4'h9);
        step((64'(1) << 5) | (64'(1) << 40), '1, '0, pr, 5'd3);
        // R6: higher priority beats higher number
        pr = setp(setp('0, 5, 4'hC), 40, 4'h9);
        step((64'(1) << 5) | (64'(1) << 40), '1, '0, pr, 5'd3);
        // R2: disabled source ignored
        step((64'(1) << 5) | (64'(1) << 40), ~(64'(1) << 5), '0, pr, 5'd3);
        // R7 / R3: fast lowest; fast excluded from normal
        pr = setp('0, 63, 4'hF);
        step((64'(1) << 63) | (64'(1) << 20) | (64'(1) << 7), '1,
             (64'(1) << 63) | (64'(1) << 20), pr, 5'd0);
        // R3: fast request with mask at every level
        step(64'(1) << 0, '1, 64'(1), '0, 5'd0);
        step('1, '1, '1, '1, 5'h1F);
        // Random patterns
        for (int k = 0; k < 400; k++) begin
            logic [255:0] rp;
            for (int w = 0; w < 8; w++) rp[32*w +: 32] = $urandom;
            step({$urandom, $urandom} & {$urandom, $urandom}, {$urandom, $urandom} | {$urandom, $urandom},
                 {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}, rp,
                 (k % 7 == 0) ? 5'h1F : 5'($urandom % 18));
        end
        step('0, '0, '0, '0, 5'h1F);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule